// File: doc/BRIEF.md
# Event Counting Performance Monitor

This block counts clock cycles and selected hardware events so that software can sample where time goes. It holds one free-running cycle counter and four event counters. Each event counter picks one line of a 32-bit vector of single-cycle event pulses through an 8-bit event code. Software reaches every register through a simple word port that has an address, write data, a write strobe and a read strobe. Read data comes back registered.

To sample at a fixed period, software loads a counter with the two's complement of the period and enables it. When the counter wraps past its all-ones value, it sets an overflow flag. If the interrupt-enable bit for that counter is set, the flag drives a registered level interrupt. The handler reads the flags, writes the same value back to clear them, and reloads the counters. The cycle counter can also advance only once every 64 clocks, for long intervals.

Register word addresses: 0 control, 1 interrupt enable, 2 overflow flags, 3 event select, 4 cycle counter, 5 to 8 event counters 0 to 3. Any other address reads as zero.

Top module: `pmu_monitor`

## Requirements
- R1: After reset, every register and counter reads 0 and `irq` is low.
- R2: Control bit 0 is the global enable and bit 3 selects divide-by-64 for the cycle counter. Only these two bits are stored, and a read of the control word returns 0 in every other bit.
- R3: While the global enable is 0, no counter advances, and software writes to the counters still take effect.
- R4: The event-select word holds one 8-bit code per event counter, with counter n in bits 8n+7:8n. A code c from 0x00 to 0x16 makes that counter add one on each clock in which `evt_pulse[c]` is high.
- R5: A counter whose code is 0xFF, or any code above 0x16, never increments.
- R6: With the enable set and bit 3 clear, the cycle counter adds one on every clock. With bit 3 set, it adds one on every 64th clock of a prescaler that runs while the enable is set.
- R7: Writing control bit 1 as 1 clears all event counters, and writing bit 2 as 1 clears the cycle counter and its prescaler. Both take effect at the edge of that write and are not stored.
- R8: A software write to a counter takes priority over an increment of that counter in the same cycle.
- R9: When a counter increments from 0xFFFFFFFF to 0, its overflow flag sets. Flag bit 0 belongs to the cycle counter and bits 1 to 4 belong to event counters 0 to 3. The interrupt-enable word uses the same bit order.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A wrap in the same cycle as the clear leaves the flag set.
- R11: `irq` is registered. It is high in the cycle after some flag and its enable bit are both 1, and flags whose enable bit is 0 never raise it.
- R12: A read strobe loads `reg_rdata` at the next edge with the register's value from before that edge, and `reg_rdata` holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| evt_pulse | input | 32 | Single-cycle event pulses |
| irq | output | 1 | Level interrupt request |

## Verification
A counter write, a clear or an increment caused by a pulse shows in the counter at the edge that samples the stimulus, and a wrap sets its flag at that same edge. `irq` follows one edge later, and read data appears one edge after its strobe. The bench drives inputs on falling edges and checks `irq` and `reg_rdata` on every falling edge against a behavioural model that advances on rising edges. Directed reads are checked at the falling edge after their strobe, and interrupt checks are placed exactly one and two edges after a wrap so that the one-cycle interrupt delay is pinned down.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  // register word addresses
  localparam int A_CTRL  = 0;
  localparam int A_INTEN = 1;
  localparam int A_OVF   = 2;
  localparam int A_EVSEL = 3;
  localparam int A_CNT0  = 4;  // cycle counter, event counters follow

  // control word bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_EVCLR = 1;
  localparam int CTL_CYCLR = 2;
  localparam int CTL_DIV   = 3;

  typedef struct packed {
    logic div;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (wr)     count <= wdata;
    else if (inc)    count <= count + 1'b1;
  end

  // a wrap only counts when the increment is not overridden
  assign wrap = inc & ~wr & ~clr & (&count);

  // R3: with no increment, write or clear the value holds
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr && !clr) |=> $stable(count));
endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int               EVT_W    = 32,
  parameter int               CODE_W   = 8,
  parameter logic [CODE_W-1:0] MAX_CODE = 8'h16
) (
  input  logic [CODE_W-1:0] code,
  input  logic [EVT_W-1:0]  evt,
  output logic              hit
);
  localparam int IDX_W = $clog2(EVT_W);

  always_comb begin
    hit = 1'b0;
    if (code <= MAX_CODE) hit = evt[code[IDX_W-1:0]];
  end
endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (en)    cnt <= cnt + 1'b1;
  end

  assign tick = en & (&cnt);
endmodule

// File: rtl/pmu_monitor.sv
module pmu_monitor #(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 4,
  parameter int                NUM_EVT  = 4,
  parameter int                EVT_W    = 32,
  parameter int                CODE_W   = 8,
  parameter int                PRESC_W  = 6,
  parameter logic [CODE_W-1:0] MAX_CODE = 8'h16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  output logic              irq
);
  import pmu_pkg::*;

  localparam int NUM_CNT = NUM_EVT + 1;
  localparam int SEL_W   = NUM_EVT * CODE_W;

  ctrl_t               ctrl_q;
  logic [NUM_CNT-1:0]  inten_q, ovf_q;
  logic [SEL_W-1:0]    evsel_q;
  logic [NUM_CNT-1:0]  cnt_inc, cnt_wrap, cnt_wr, cnt_clr;
  logic [DATA_W-1:0]   cnt_val [NUM_CNT];
  logic [NUM_EVT-1:0]  evt_hit;
  logic [DATA_W-1:0]   rd_mux;
  logic [NUM_CNT-1:0]  ovf_w1c;
  logic                wr_ctrl, wr_inten, wr_ovf, wr_evsel;
  logic                evt_clr, cyc_clr, presc_tick;

  assign wr_ctrl  = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_inten = reg_wr && (reg_addr == ADDR_W'(A_INTEN));
  assign wr_ovf   = reg_wr && (reg_addr == ADDR_W'(A_OVF));
  assign wr_evsel = reg_wr && (reg_addr == ADDR_W'(A_EVSEL));
  assign evt_clr  = wr_ctrl && reg_wdata[CTL_EVCLR];
  assign cyc_clr  = wr_ctrl && reg_wdata[CTL_CYCLR];
  assign ovf_w1c  = wr_ovf ? reg_wdata[NUM_CNT-1:0] : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      inten_q <= '0;
      evsel_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.en  <= reg_wdata[CTL_EN];
        ctrl_q.div <= reg_wdata[CTL_DIV];
      end
      if (wr_inten) inten_q <= reg_wdata[NUM_CNT-1:0];
      if (wr_evsel) evsel_q <= reg_wdata[SEL_W-1:0];
    end
  end

  pmu_prescale #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .clr(cyc_clr), .en(ctrl_q.en), .tick(presc_tick)
  );

  assign cnt_inc[0] = ctrl_q.en & (~ctrl_q.div | presc_tick);
  assign cnt_clr[0] = cyc_clr;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    pmu_evt_sel #(.EVT_W(EVT_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_sel (
      .code(evsel_q[e*CODE_W +: CODE_W]), .evt(evt_pulse), .hit(evt_hit[e])
    );
    assign cnt_inc[e+1] = ctrl_q.en & evt_hit[e];
    assign cnt_clr[e+1] = evt_clr;

    // R5: an unused code leaves the counter untouched
    p_unused_code_r5: assert property (@(posedge clk) disable iff (rst)
      (evsel_q[e*CODE_W +: CODE_W] == 8'hFF && !cnt_wr[e+1] && !cnt_clr[e+1])
        |=> $stable(cnt_val[e+1]));
  end

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    assign cnt_wr[k] = reg_wr && (reg_addr == ADDR_W'(A_CNT0 + k));
    pmu_counter #(.W(DATA_W)) u_cnt (
      .clk(clk), .rst(rst), .clr(cnt_clr[k]), .wr(cnt_wr[k]),
      .wdata(reg_wdata), .inc(cnt_inc[k]), .count(cnt_val[k]), .wrap(cnt_wrap[k])
    );

    // R9: an all-ones counter that steps leaves its flag set
    p_wrap_flag_r9: assert property (@(posedge clk) disable iff (rst)
      (cnt_inc[k] && (&cnt_val[k]) && !cnt_wr[k] && !cnt_clr[k]) |=> ovf_q[k]);
    // R10: a one written to a flag with no wrap clears it
    p_w1c_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_ovf && reg_wdata[k] && !cnt_wrap[k]) |=> !ovf_q[k]);
  end

  // overflow flags: set by a wrap, cleared by write-one, set wins
  always_ff @(posedge clk) begin
    if (rst) ovf_q <= '0;
    else     ovf_q <= (ovf_q & ~ovf_w1c) | cnt_wrap;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(ovf_q & inten_q);
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      rd_mux[CTL_EN]  = ctrl_q.en;
      rd_mux[CTL_DIV] = ctrl_q.div;
    end
    if (reg_addr == ADDR_W'(A_INTEN)) rd_mux[NUM_CNT-1:0] = inten_q;
    if (reg_addr == ADDR_W'(A_OVF))   rd_mux[NUM_CNT-1:0] = ovf_q;
    if (reg_addr == ADDR_W'(A_EVSEL)) rd_mux[SEL_W-1:0]   = evsel_q;
    for (int k = 0; k < NUM_CNT; k++)
      if (reg_addr == ADDR_W'(A_CNT0 + k)) rd_mux = cnt_val[k];
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R2: undefined control bits always read back as zero
  p_ctrl_rsvd_r2: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADDR_W'(A_CTRL))
      |=> (reg_rdata[DATA_W-1:4] == '0 && reg_rdata[2:1] == 2'b00));

  // R11: with all enables clear for two cycles the interrupt stays low
  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    (inten_q == '0 && $past(inten_q) == '0) |-> !irq);
endmodule

// File: tb/tb_pmu_monitor.sv
module tb_pmu_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic [31:0] evt_pulse = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pmu_monitor dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt [5];
  bit          m_en, m_div, m_irq;
  logic [4:0]  m_inten, m_ovf, m_wraps, m_w1c;
  logic [31:0] m_evsel, m_rdata, m_rv;
  int          m_presc;
  bit          m_tick;
  logic [4:0]  m_inc;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 5; k++) m_cnt[k] = 0;
      m_en = 0; m_div = 0; m_irq = 0; m_inten = 0; m_ovf = 0;
      m_evsel = 0; m_rdata = 0; m_presc = 0;
    end else begin
      m_rv = 0;
      case (reg_addr)
        4'd0: m_rv = {28'd0, m_div, 2'b00, m_en};
        4'd1: m_rv = {27'd0, m_inten};
        4'd2: m_rv = {27'd0, m_ovf};
        4'd3: m_rv = m_evsel;
        4'd4, 4'd5, 4'd6, 4'd7, 4'd8: m_rv = m_cnt[reg_addr - 4];
        default: m_rv = 0;
      endcase
      if (reg_rd) m_rdata = m_rv;
      m_irq = |(m_ovf & m_inten);
      m_tick = m_div ? (m_presc % 64 == 63) : 1'b1;
      m_inc[0] = m_en && m_tick;
      for (int e = 0; e < 4; e++) begin
        int code;
        code = m_evsel[8*e +: 8];
        m_inc[e+1] = m_en && code <= 22 && evt_pulse[code % 32];
      end
      if (reg_wr && reg_addr == 0 && reg_wdata[2]) m_presc = 0;
      else if (m_en) m_presc = m_presc + 1;
      m_wraps = 0;
      for (int k = 0; k < 5; k++) begin
        if (reg_wr && reg_addr == 0 && (k == 0 ? reg_wdata[2] : reg_wdata[1]))
          m_cnt[k] = 0;
        else if (reg_wr && reg_addr == 4 + k) m_cnt[k] = reg_wdata;
        else if (m_inc[k]) begin
          if (m_cnt[k] == 32'hFFFF_FFFF) m_wraps[k] = 1'b1;
          m_cnt[k] = m_cnt[k] + 1;
        end
      end
      m_w1c = (reg_wr && reg_addr == 2) ? reg_wdata[4:0] : 5'd0;
      m_ovf = (m_ovf & ~m_w1c) | m_wraps;
      if (reg_wr && reg_addr == 0) begin m_en = reg_wdata[0]; m_div = reg_wdata[3]; end
      if (reg_wr && reg_addr == 1) m_inten = reg_wdata[4:0];
      if (reg_wr && reg_addr == 3) m_evsel = reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every falling edge: compare outputs against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(reg_rdata === m_rdata, "R12 model rdata", reg_rdata, m_rdata);
      chk(irq === m_irq, "R11 model irq", {31'd0, irq}, {31'd0, m_irq});
    end
  end

  // ---------------- stimulus tasks (start just after a falling edge) ----
  task automatic access(input bit w, input bit r, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] ev);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt_pulse = ev;
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; evt_pulse = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    access(1, 0, a, d, 0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    access(0, 1, a, 0, 0);
    chk(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [31:0] ev);
    access(0, 0, 0, 0, ev);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [31:0] saved;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    for (int a = 0; a < 9; a++) rd(4'(a), 0, "R1 reset read");

    // R2 control read-back mask
    wr(0, 32'hFFFF_FFFF);
    rd(0, 32'h0000_0009, "R2 ctrl readback");
    wr(0, 0);

    // R12 read in the same cycle as a write returns the old value
    access(1, 1, 8, 32'h55, 0);
    chk(reg_rdata === 0, "R12 read before write", reg_rdata, 0);
    rd(8, 32'h55, "R12 read after write");
    wr(8, 0);

    // R6 cycle counter, undivided
    wr(4, 0);
    wr(0, 1);
    idle(9);
    wr(0, 0);
    rd(4, 10, "R6 cycle count");

    // R4 / R5 event selection
    wr(3, 32'hFF16_0500);
    wr(0, 1);
    pulse(32'h0040_0021);
    pulse(32'h0000_0021);
    pulse(32'h0000_0001);
    pulse(32'hFFFF_FFFF);
    rd(5, 4, "R4 counter0 code 0x00");
    rd(6, 3, "R4 counter1 code 0x05");
    rd(7, 2, "R4 counter2 code 0x16");
    rd(8, 0, "R5 counter3 code 0xFF");
    wr(3, 32'h3016_0500);
    pulse(32'hFFFF_FFFF);
    rd(8, 0, "R5 counter3 code 0x30");
    rd(5, 5, "R4 counter0 after all pulse");

    // R8 write beats increment
    access(1, 0, 5, 32'h100, 32'h1);
    rd(5, 32'h100, "R8 write priority");

    // R9 / R11 overflow and interrupt timing
    wr(1, 32'h02);
    wr(5, 32'hFFFF_FFFE);
    pulse(1);
    pulse(1);
    chk(irq === 1'b0, "R11 irq registered delay", {31'd0, irq}, 0);
    idle(1);
    chk(irq === 1'b1, "R11 irq raised", {31'd0, irq}, 1);
    rd(2, 32'h02, "R9 counter0 flag");
    rd(5, 0, "R9 counter wrapped to 0");
    wr(2, 32'h02);
    idle(1);
    chk(irq === 1'b0, "R10 irq drops after clear", {31'd0, irq}, 0);
    rd(2, 0, "R10 flag cleared");
    wr(7, 32'hFFFF_FFFF);
    pulse(32'h0040_0000);
    idle(2);
    chk(irq === 1'b0, "R11 masked flag", {31'd0, irq}, 0);
    rd(2, 32'h08, "R9 counter2 flag");
    wr(2, 32'h01);
    rd(2, 32'h08, "R10 zero bits keep flag");
    wr(5, 32'hFFFF_FFFF);
    access(1, 0, 2, 32'h0A, 32'h1);
    rd(2, 32'h02, "R10 set wins over clear");
    wr(2, 32'h02);

    // R3 disabled counters hold, writes still land
    wr(0, 0);
    pulse(1);
    pulse(1);
    rd(5, 0, "R3 no count when disabled");
    wr(6, 32'h1234);
    rd(6, 32'h1234, "R3 write while disabled");

    // R7 clear pulses
    access(0, 1, 4, 0, 0);
    saved = reg_rdata;
    wr(0, 32'h2);
    rd(6, 0, "R7 event counters cleared");
    rd(4, saved, "R7 cycle counter kept");
    wr(0, 32'h4);
    rd(4, 0, "R7 cycle counter cleared");

    // R6 divide-by-64
    wr(0, 32'h9);
    idle(130);
    wr(0, 0);
    rd(4, 2, "R6 divided cycle count");

    finish_run();
  end
endmodule